// File: doc/BRIEF.md
# Parallel-In Serial-Out FIFO

This block buffers 16-bit words that arrive in parallel and hands them out one bit at a time. A producer writes a word with a low-going pulse on an active-low write strobe; a consumer pulls bits by toggling a serial clock, receiving one bit per rising edge. Both the strobe and the serial clock are plain inputs sampled as edges inside a single system clock domain, so the block has no clock crossing of its own.

Words leave in arrival order. A direction input selects, bit by bit, whether a word goes out lowest bit first or highest bit first. Four active-low flags report the fill level: empty, full, more-than-half-full, and a two-sided almost flag that is low near either end of the range. The almost band uses one eighth and seven eighths of the depth. The depth is a parameter, with 256, 512 and 1024 words as the intended sizes.

The data interface is strobe based and not valid/ready. Back-pressure works as follows. The full flag is the only ready indication. A strobe whose falling edge finds the buffer full is dropped, and the producer has to retry. A serial edge that arrives while the buffer is empty is dropped in the same way.

Top module: `pso_fifo`

## Requirements
- R1: During and right after reset `empty_n`=0, `full_n`=1, `half_n`=1, `almost_n`=0 and `so`=0. Both pointers and the fill count start at zero.
- R2: A pulse on `wr_n` (a high-to-low change followed by a low-to-high change) whose falling edge finds the buffer not full stores the value on `din` in the system clock in which `wr_n` is first seen high again. It raises the count by one in that same clock.
- R3: A strobe whose falling edge finds `full_n`=0 stores nothing and leaves the count unchanged.
- R4: Each rising edge of `sclk` seen while the buffer is not empty puts one bit of the head word on `so`, valid from the system clock edge that detects it. Words are emitted in write order, 16 bits each.
- R5: `msb_first`=0 at the detecting clock emits bit k of the word on the k-th edge, counting from 0. `msb_first`=1 emits bit 15-k.
- R6: Rising edges of `sclk` while empty (`empty_n`=0) are ignored: `so` keeps the last bit and no pointer moves.
- R7: A word leaves the count on the clock that emits its 16th bit. The following edge starts the next word.
- R8: `empty_n` is low exactly when the count is 0. `full_n` is low exactly when the count equals DEPTH.
- R9: `half_n` is low exactly when the count exceeds DEPTH/2.
- R10: `almost_n` is low exactly when the count is at most DEPTH/8-1 or at least 7*DEPTH/8+1.
- R11: A write commit and a word retirement in the same clock leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 16 | Parallel write word |
| sclk | input | 1 | Serial shift clock, sampled for rising edges |
| msb_first | input | 1 | Bit order: 0 lowest bit first, 1 highest bit first |
| so | output | 1 | Serial data out |
| empty_n | output | 1 | Low when empty |
| full_n | output | 1 | Low when full |
| half_n | output | 1 | Low when more than half full |
| almost_n | output | 1 | Low in the almost-empty or almost-full band |

## Verification
The write commit and the retirement of the head word after its 16th bit can fall in the same system clock. The bench provokes this by shifting 15 bits of a word and then releasing the write strobe in the same cycle as the serial edge that carries the last bit. The fill level sits just above half depth at that moment, so any net change flips the half-full flag. A later count of the writes needed to reach full also confirms the level, and the data order on readback confirms that the word written in that cycle was stored.

// File: rtl/pso_pkg.sv
package pso_pkg;
  typedef enum logic {
    ORDER_LSB = 1'b0,
    ORDER_MSB = 1'b1
  } order_e;
endpackage

// File: rtl/pso_edge.sv
module pso_edge #(
  parameter logic IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= IDLE;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/pso_wr_ctrl.sv
module pso_wr_ctrl #(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic [W-1:0]  din,
  input  logic          full,
  output logic          commit,
  output logic [AW-1:0] wr_addr,
  output logic [W-1:0]  wr_data
);
  logic strobe_rise, strobe_fall;
  logic armed;

  pso_edge #(.IDLE(1'b1)) u_wedge (
    .clk(clk), .rst_n(rst_n), .lvl(wr_n),
    .rise(strobe_rise), .fall(strobe_fall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           armed <= 1'b0;
    else if (strobe_fall) armed <= ~full;
    else if (strobe_rise) armed <= 1'b0;
  end

  assign commit  = strobe_rise & armed;
  assign wr_data = din;

  always_ff @(posedge clk) begin
    if (!rst_n)      wr_addr <= '0;
    else if (commit) wr_addr <= wr_addr + 1'b1;
  end

  // R3: a strobe that starts while full never commits
  p_blocked_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_fall && full) |=> !commit);
endmodule

// File: rtl/pso_store.sv
module pso_store #(
  parameter int W     = 16,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];
endmodule

// File: rtl/pso_serializer.sv
module pso_serializer
  import pso_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          msb_first,
  input  logic          empty,
  input  logic [W-1:0]  rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          word_done,
  output logic          so
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [BW-1:0] TOP = BW'(W - 1);

  logic          srise, sfall_unused;
  logic          shift;
  logic [BW-1:0] bit_idx;
  logic [BW-1:0] pos;
  order_e        ord;

  pso_edge #(.IDLE(1'b0)) u_sedge (
    .clk(clk), .rst_n(rst_n), .lvl(sclk),
    .rise(srise), .fall(sfall_unused)
  );

  assign shift     = srise & ~empty;
  assign word_done = shift & (bit_idx == TOP);
  assign ord       = order_e'(msb_first);
  assign pos       = (ord == ORDER_MSB) ? (TOP - bit_idx) : bit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx <= '0;
      so      <= 1'b0;
      rd_addr <= '0;
    end else if (shift) begin
      so      <= rd_data[pos];
      bit_idx <= (bit_idx == TOP) ? '0 : bit_idx + 1'b1;
      if (bit_idx == TOP) rd_addr <= rd_addr + 1'b1;
    end
  end

  // R6: serial edges during empty leave the output bit alone
  p_hold_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (srise && empty) |=> $stable(so));
  // R6: the read pointer does not move while empty
  p_ptr_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> $stable(rd_addr));
endmodule

// File: rtl/pso_level.sv
module pso_level #(
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic empty,
  output logic full,
  output logic empty_n,
  output logic full_n,
  output logic half_n,
  output logic almost_n
);
  localparam logic [CW-1:0] C_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] C_HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] C_LOW  = CW'(DEPTH / 8);
  localparam logic [CW-1:0] C_HIGH = CW'((7 * DEPTH) / 8);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else begin
      case ({inc, dec})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign empty    = (count == '0);
  assign full     = (count == C_FULL);
  assign empty_n  = ~empty;
  assign full_n   = ~full;
  assign half_n   = ~(count > C_HALF);
  assign almost_n = ~((count < C_LOW) || (count > C_HIGH));

  // R3: a commit never lands on a full buffer
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |-> !full);
  // R6: a retirement never lands on an empty buffer
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !empty);
  // R11: paired commit and retirement keep the level
  p_pair_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(count));
  // R8: empty and full are never low together
  p_excl_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_n && !full_n));
  // R10: both extremes lie in the almost band
  p_ends_almost_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n || !full_n) |-> !almost_n);
endmodule

// File: rtl/pso_fifo.sv
module pso_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_n,
  input  logic [W-1:0] din,
  input  logic         sclk,
  input  logic         msb_first,
  output logic         so,
  output logic         empty_n,
  output logic         full_n,
  output logic         half_n,
  output logic         almost_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          commit, word_done, empty, full;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [W-1:0]  wr_data, rd_data;

  pso_wr_ctrl #(.W(W), .AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .din(din), .full(full),
    .commit(commit), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  pso_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(commit), .wa(wr_addr), .wd(wr_data),
    .ra(rd_addr), .rd(rd_data)
  );

  pso_serializer #(.W(W), .AW(AW)) u_ser (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .msb_first(msb_first),
    .empty(empty), .rd_data(rd_data), .rd_addr(rd_addr),
    .word_done(word_done), .so(so)
  );

  pso_level #(.DEPTH(DEPTH), .CW(CW)) u_lvl (
    .clk(clk), .rst_n(rst_n), .inc(commit), .dec(word_done),
    .empty(empty), .full(full), .empty_n(empty_n), .full_n(full_n),
    .half_n(half_n), .almost_n(almost_n)
  );

  // R2: pointers differ by the level, so equal pointers mean empty or full
  p_ptr_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr != rd_addr) |-> (empty_n && full_n));
  // R1: reset leaves the flags at their idle levels on the next clock
  p_reset_flags_r1: assert property (@(posedge clk)
    !rst_n |=> (!empty_n && full_n && half_n && !almost_n));
endmodule

// File: tb/sim_pso_fifo.sv
module sim_pso_fifo;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1;
  logic [15:0] din = '0;
  logic sclk = 1'b0;
  logic msb_first = 1'b0;
  logic so, empty_n, full_n, half_n, almost_n;

  int errors = 0;
  int checks = 0;
  int level = 0;
  logic [15:0] model [$];
  bit done = 0;

  always #4 clk = ~clk;

  pso_fifo #(.W(16), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .din(din), .sclk(sclk),
    .msb_first(msb_first), .so(so), .empty_n(empty_n), .full_n(full_n),
    .half_n(half_n), .almost_n(almost_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    int e_exp, f_exp, h_exp, a_exp;
    e_exp = (level == 0) ? 0 : 1;
    f_exp = (level == D) ? 0 : 1;
    h_exp = (level > D / 2) ? 0 : 1;
    a_exp = (level <= D / 8 - 1 || level >= 7 * D / 8 + 1) ? 0 : 1;
    chk(empty_n == e_exp, {req, " R8 empty_n"}, empty_n, e_exp);
    chk(full_n == f_exp, {req, " R8 full_n"}, full_n, f_exp);
    chk(half_n == h_exp, {req, " R9 half_n"}, half_n, h_exp);
    chk(almost_n == a_exp, {req, " R10 almost_n"}, almost_n, a_exp);
  endtask

  task automatic write_word(input logic [15:0] w);
    bit accept;
    accept = (level < D);
    @(negedge clk); wr_n = 1'b0; din = w;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
    if (accept) begin model.push_back(w); level++; end
  endtask

  task automatic shift_bit(input bit msb, input int k, input string req);
    logic [15:0] head;
    int exp_bit;
    bit retire;
    head = model[0];
    exp_bit = msb ? head[15 - k] : head[k];
    retire = (k == 15);
    @(negedge clk); sclk = 1'b1; msb_first = msb;
    @(negedge clk);
    chk(so == exp_bit, req, so, exp_bit);
    if (retire) begin void'(model.pop_front()); level--; end
    sclk = 1'b0;
  endtask

  task automatic read_word(input bit msb);
    for (int k = 0; k < 16; k++)
      shift_bit(msb, k, msb ? "R5 msb-first bit" : "R4 lsb-first bit");
    chk_flags("R7 after word");
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic last_so;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(so == 1'b0, "R1 so", so, 0);
    chk_flags("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R8/R9/R10: fill sweep with flags checked at every level
    for (int i = 0; i < D; i++) begin
      write_word(16'hA500 ^ 16'(i * 16'h0137));
      chk_flags("R2 fill");
    end
    // R3: write while full ignored
    write_word(16'hDEAD);
    chk_flags("R3 full write");

    // R4/R5/R7: drain sweep, alternating bit order
    for (int i = 0; i < D; i++) read_word(i[0]);
    chk(model.size() == 0, "R4 drained", model.size(), 0);

    // R6: serial edges while empty are ignored
    last_so = so;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
      chk(so == last_so, "R6 hold so", so, last_so);
    end
    chk_flags("R6 empty");

    // R6: pointer unmoved, next word comes out intact
    write_word(16'h8001);
    read_word(1'b0);

    // R11: commit and retirement in the same clock at level 9
    for (int i = 0; i < 9; i++) write_word(16'h1111 * 16'(i + 1));
    chk_flags("R11 pre");
    for (int k = 0; k < 15; k++) shift_bit(1'b1, k, "R5 msb-first bit");
    begin
      logic [15:0] head;
      int exp_bit;
      head = model[0];
      exp_bit = head[0];
      @(negedge clk); wr_n = 1'b0; din = 16'h5AC3;
      @(negedge clk); wr_n = 1'b1; sclk = 1'b1; msb_first = 1'b1;
      @(negedge clk);
      chk(so == exp_bit, "R11 last bit", so, exp_bit);
      void'(model.pop_front());
      model.push_back(16'h5AC3);
      sclk = 1'b0;
    end
    chk(half_n == 1'b0, "R11 level kept half_n", half_n, 0);
    chk_flags("R11 post");
    for (int i = 0; i < 6; i++) write_word(16'h0F0F + 16'(i));
    chk(full_n == 1'b1, "R11 one short of full", full_n, 1);
    write_word(16'hF00D);
    chk_flags("R11 full");
    while (model.size() > 0) read_word(model.size() % 2 == 1);
    chk_flags("R7 final");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule